// File: doc/BRIEF.md
# Ordered Multi-Level Synaptic Gate Chain

This block stores the strength of one learned synapse as a chain of self-holding gate cells. With `N_GATES` gates it gives `N_GATES+1` strength levels. A learning detector outside the block sends single-cycle potentiate and depress events. A potentiate event turns on the lowest gate that is still off, but only if the gate below it is on. A depress event turns off the highest gate that is on, but only if the gate above it is off. Because every update depends on a neighbour, the gates always form a thermometer code: the active gates run without a gap from gate 1 upward.

Every gate drives its own relay cell. When a presynaptic spike arrives, each relay whose gate is active sends one spike toward the postsynaptic neuron in the next step. The number of relayed spikes in a step is the effective weight of the synapse applied to the input spike. The gate states are brought out so the stored level can be observed directly.

Top module: `gate_chain_synapse`

## Requirements
- R1: A synchronous reset (`rst_n` low at a clock edge) clears every gate and every relay, so `gate_o`, `relay_o` and `relay_count_o` all read zero after that edge.
- R2: A potentiate event alone (`pot_i`=1, `dep_i`=0) turns on exactly one gate, the lowest inactive one. Bit k of `gate_o` is gate k+1, so the level rises by one and bit `level` becomes set.
- R3: A depress event alone (`dep_i`=1, `pot_i`=0) turns off exactly one gate, the highest active one, so the level falls by one.
- R4: A potentiate event when all gates are on, or a depress event when all gates are off, leaves `gate_o` unchanged.
- R5: When `pot_i` and `dep_i` are both high in the same cycle, `gate_o` is unchanged.
- R6: When no event arrives, every gate keeps its state for any number of cycles.
- R7: A relay output `relay_o[k]` is high for the single cycle after a cycle in which `pre_spike_i` was high, and only if gate k was active in the spike cycle, before any event in that cycle takes effect.
- R8: `relay_count_o` equals the number of relays that are high. That equals the level held when the spike arrived, and it is zero in any cycle that does not follow a spike.
- R9: `gate_o` is always a thermometer code: its set bits run without a gap from bit 0 upward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Step clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pot_i | input | 1 | Potentiate event from the learning detector |
| dep_i | input | 1 | Depress event from the learning detector |
| pre_spike_i | input | 1 | Presynaptic spike |
| gate_o | output | N_GATES | Gate states; bit k is gate k+1 |
| relay_o | output | N_GATES | Relayed spikes, one per gate path |
| relay_count_o | output | $clog2(N_GATES+1) | Number of relayed spikes this step |

## Verification
A wrong gate state shows on `gate_o` in the cycle after the faulty event, as a level off by one or as a gap in the thermometer code. The same error shows on the relay count after the next presynaptic spike. A relay that takes the gate value from after the update instead of before it shows only when a spike and an event arrive in the same cycle, so the bench drives that case on purpose. It also drives spikes at both the empty and the full level, so that any relay path stuck on or stuck off produces a wrong count within one step.

// File: rtl/gchain_pkg.sv
// Package: shared types for the synaptic gate chain.
// Assumes: at most one event class is applied per step.
package gchain_pkg;

    // Learning event that the detector applies in one step
    typedef enum logic [1:0] {
        EV_IDLE = 2'd0,
        EV_UP   = 2'd1,
        EV_DOWN = 2'd2,
        EV_VOID = 2'd3
    } gchain_ev_t;

    // Maps the two raw event lines to one event class; a collision cancels
    function automatic gchain_ev_t classify_event(input logic up, input logic down);
        gchain_ev_t ev;
        case ({up, down})
            2'b10:   ev = EV_UP;
            2'b01:   ev = EV_DOWN;
            2'b11:   ev = EV_VOID;
            default: ev = EV_IDLE;
        endcase
        return ev;
    endfunction

endpackage

// File: rtl/gchain_event_decode.sv
// Module: gchain_event_decode
// Turns the potentiate and depress lines into one event class for the step.
// Assumes: both inputs are synchronous to clk; a same-step pair is cancelled.
module gchain_event_decode
    import gchain_pkg::*;
(
    input  logic       pot,
    input  logic       dep,
    output gchain_ev_t ev
);

    // Purpose: classify the raw event lines
    always_comb begin
        ev = classify_event(pot, dep);
    end

endmodule

// File: rtl/gchain_gate_cell.sv
// Module: gchain_gate_cell
// One self-holding gate neuron. It turns on for an up event only when the
// gate below is active, and turns off for a down event only when the gate
// above is inactive. With no event, self-excitation keeps the state.
// Assumes: below_on is tied high for the first gate, above_on is tied low
// for the last gate.
module gchain_gate_cell
    import gchain_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  gchain_ev_t ev,
    input  logic       below_on,
    input  logic       above_on,
    output logic       on
);

    logic on_next;

    // Purpose: work out the next gate state from the event and the neighbours
    always_comb begin
        on_next = on;
        case (ev)
            EV_UP:   if (!on && below_on) on_next = 1'b1;
            EV_DOWN: if (on && !above_on) on_next = 1'b0;
            default: on_next = on;
        endcase
    end

    // Purpose: gate state register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on <= 1'b0;
        end else begin
            on <= on_next;
        end
    end

endmodule

// File: rtl/gchain_relay_cell.sv
// Module: gchain_relay_cell
// Relay neuron for one gate path. It passes a presynaptic spike one step
// later, but only if its gate is active in the step the spike arrives.
// Assumes: gate_on is the registered gate state, taken before any update.
module gchain_relay_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic pre_spike,
    input  logic gate_on,
    output logic relay
);

    // Purpose: register the gated spike
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            relay <= 1'b0;
        end else begin
            relay <= pre_spike & gate_on;
        end
    end

endmodule

// File: rtl/gchain_popcount.sv
// Module: gchain_popcount
// Counts the set bits of a vector.
// Assumes: CNT_W is wide enough to hold WIDTH.
module gchain_popcount #(
    parameter int WIDTH = 4,
    parameter int CNT_W = $clog2(WIDTH + 1)
) (
    input  logic [WIDTH-1:0] bits,
    output logic [CNT_W-1:0] count
);

    // Purpose: add up the set bits
    always_comb begin
        count = '0;
        for (int i = 0; i < WIDTH; i++) begin
            count = count + CNT_W'(bits[i]);
        end
    end

endmodule

// File: rtl/gate_chain_synapse.sv
// Module: gate_chain_synapse (top)
// Stores a synapse weight as an ordered chain of N_GATES self-holding gates
// and relays presynaptic spikes through one path per active gate. Each gate
// is updated only with the support of its neighbours, so up events fill the
// chain upward and down events empty it downward.
// Assumes: N_GATES is 1 to 8; events come as single-step pulses.
module gate_chain_synapse
    import gchain_pkg::*;
#(
    parameter  int N_GATES = 4,
    localparam int CNT_W   = $clog2(N_GATES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pot_i,
    input  logic               dep_i,
    input  logic               pre_spike_i,
    output logic [N_GATES-1:0] gate_o,
    output logic [N_GATES-1:0] relay_o,
    output logic [CNT_W-1:0]   relay_count_o
);

    gchain_ev_t         ev;
    logic [N_GATES-1:0] gate_q;
    logic [N_GATES-1:0] below_sup;
    logic [N_GATES-1:0] above_sup;

    gchain_event_decode u_decode (
        .pot (pot_i),
        .dep (dep_i),
        .ev  (ev)
    );

    // Neighbour excitation and one gate and relay per level
    for (genvar k = 0; k < N_GATES; k++) begin : g_level
        if (k == 0) begin : g_first
            assign below_sup[k] = 1'b1;
        end else begin : g_mid_lo
            assign below_sup[k] = gate_q[k-1];
        end
        if (k == N_GATES - 1) begin : g_last
            assign above_sup[k] = 1'b0;
        end else begin : g_mid_hi
            assign above_sup[k] = gate_q[k+1];
        end

        gchain_gate_cell u_gate (
            .clk      (clk),
            .rst_n    (rst_n),
            .ev       (ev),
            .below_on (below_sup[k]),
            .above_on (above_sup[k]),
            .on       (gate_q[k])
        );

        gchain_relay_cell u_relay (
            .clk       (clk),
            .rst_n     (rst_n),
            .pre_spike (pre_spike_i),
            .gate_on   (gate_q[k]),
            .relay     (relay_o[k])
        );
    end

    gchain_popcount #(
        .WIDTH (N_GATES),
        .CNT_W (CNT_W)
    ) u_count (
        .bits  (relay_o),
        .count (relay_count_o)
    );

    assign gate_o = gate_q;

endmodule

// File: rtl/gate_chain_synapse_chk.sv
// Module: gate_chain_synapse_chk
// Property checker for gate_chain_synapse, attached by bind below.
// Assumes: it sees the same clock and reset as the top module.
module gate_chain_synapse_chk #(
    parameter  int N_GATES = 4,
    localparam int CNT_W   = $clog2(N_GATES + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pot_i,
    input logic               dep_i,
    input logic               pre_spike_i,
    input logic [N_GATES-1:0] gate_o,
    input logic [N_GATES-1:0] relay_o,
    input logic [CNT_W-1:0]   relay_count_o
);

    localparam logic [N_GATES-1:0] ONE_V = N_GATES'(1);

    // R9: set bits run without a gap from bit 0
    assert_thermometer_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_o & (gate_o + ONE_V)) == '0);

    // R2: a lone up event below full raises the level by one
    assert_up_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pot_i && !dep_i && !(&gate_o)) |=>
        ($countones(gate_o) == $countones($past(gate_o)) + 1));

    // R3: a lone down event above empty lowers the level by one
    assert_down_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dep_i && !pot_i && (|gate_o)) |=>
        ($countones(gate_o) + 1 == $countones($past(gate_o))));

    // R4: an up event at full level has no effect
    assert_sat_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pot_i && !dep_i && (&gate_o)) |=> $stable(gate_o));

    // R4: a down event at zero level has no effect
    assert_sat_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dep_i && !pot_i && !(|gate_o)) |=> $stable(gate_o));

    // R5 and R6: no lone event leaves the gates unchanged
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pot_i == dep_i) |=> $stable(gate_o));

    // R7: relays follow the gate state of the spike step
    assert_relay_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pre_spike_i |=> (relay_o == $past(gate_o)));

    // R8: no spike, no relayed count in the next step
    assert_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pre_spike_i |=> (relay_count_o == '0));

    // R8: the count equals the level held at spike time
    assert_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pre_spike_i |=> (32'(relay_count_o) == $countones($past(gate_o))));

endmodule

bind gate_chain_synapse gate_chain_synapse_chk #(.N_GATES(N_GATES)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pot_i         (pot_i),
    .dep_i         (dep_i),
    .pre_spike_i   (pre_spike_i),
    .gate_o        (gate_o),
    .relay_o       (relay_o),
    .relay_count_o (relay_count_o)
);

// File: tb/test_gate_chain_synapse.sv
// Scoreboard bench: the driver task computes the expected gates and relays
// for each step and queues them; the monitor compares them after the edge.
module test_gate_chain_synapse;

    localparam int CLK_PERIOD = 10;
    localparam int NG         = 4;
    localparam int CW         = $clog2(NG + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pot_i = 1'b0;
    logic          dep_i = 1'b0;
    logic          pre_spike_i = 1'b0;
    logic [NG-1:0] gate_o;
    logic [NG-1:0] relay_o;
    logic [CW-1:0] relay_count_o;

    int n_checks = 0;
    int n_fails  = 0;
    int level    = 0;
    bit done     = 1'b0;

    logic [NG-1:0] exp_gate_q[$];
    logic [NG-1:0] exp_relay_q[$];
    int            exp_cnt_q[$];
    string         tag_q[$];

    gate_chain_synapse #(.N_GATES(NG)) i_gate_chain_synapse (
        .clk           (clk),
        .rst_n         (rst_n),
        .pot_i         (pot_i),
        .dep_i         (dep_i),
        .pre_spike_i   (pre_spike_i),
        .gate_o        (gate_o),
        .relay_o       (relay_o),
        .relay_count_o (relay_count_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [NG-1:0] thermo(input int lvl);
        logic [NG-1:0] v = '0;
        for (int i = 0; i < lvl; i++) v[i] = 1'b1;
        return v;
    endfunction

    // Driver: apply one step and queue its expected result
    task automatic step(input bit rst, input bit pot, input bit dep,
                        input bit pre, input string tag);
        logic [NG-1:0] er;
        @(negedge clk);
        rst_n = ~rst; pot_i = pot; dep_i = dep; pre_spike_i = pre;
        er = pre ? thermo(level) : '0;
        if (rst) begin
            level = 0;
            er = '0;
        end else if (pot && !dep) begin
            if (level < NG) level++;
        end else if (dep && !pot) begin
            if (level > 0) level--;
        end
        exp_gate_q.push_back(thermo(level));
        exp_relay_q.push_back(er);
        exp_cnt_q.push_back($countones(er));
        tag_q.push_back(tag);
    endtask

    // Monitor: compare outputs just after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_gate_q.size() > 0) begin
                logic [NG-1:0] eg, er;
                int ec;
                string t;
                eg = exp_gate_q.pop_front();
                er = exp_relay_q.pop_front();
                ec = exp_cnt_q.pop_front();
                t  = tag_q.pop_front();
                n_checks++;
                if (gate_o !== eg) begin
                    n_fails++;
                    $display("FAIL %s gates: got %b expected %b", t, gate_o, eg);
                end
                n_checks++;
                if (relay_o !== er) begin
                    n_fails++;
                    $display("FAIL %s relays: got %b expected %b", t, relay_o, er);
                end
                n_checks++;
                if (int'(relay_count_o) != ec) begin
                    n_fails++;
                    $display("FAIL %s count: got %0d expected %0d", t, relay_count_o, ec);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] lfsr = 8'hA5;
        repeat (3) step(1, 0, 0, 0, "R1_reset");
        step(0, 0, 0, 1, "R7_spike_empty");
        step(0, 0, 0, 0, "R8_quiet");
        step(0, 1, 0, 0, "R2_first_gate");
        step(0, 0, 0, 1, "R7_one_path");
        step(0, 0, 0, 0, "R8_after_spike");
        step(0, 1, 0, 1, "R7_old_level_on_up");
        step(0, 0, 0, 0, "R8_count_two");
        repeat (20) step(0, 0, 0, 0, "R6_hold");
        step(0, 0, 0, 1, "R6_hold_spike");
        step(0, 1, 0, 0, "R2_third_gate");
        step(0, 1, 0, 0, "R2_fourth_gate");
        step(0, 1, 0, 0, "R4_up_at_full");
        step(0, 0, 0, 1, "R8_full_count");
        step(0, 1, 1, 1, "R5_both_full");
        step(0, 0, 0, 0, "R8_after_full");
        step(0, 0, 1, 0, "R3_drop_top");
        step(0, 0, 1, 1, "R7_old_level_on_down");
        step(0, 0, 1, 0, "R3_drop_next");
        step(0, 0, 1, 0, "R3_drop_last");
        step(0, 0, 1, 0, "R4_down_at_empty");
        step(0, 1, 1, 0, "R5_both_empty");
        step(0, 0, 0, 1, "R8_empty_count");
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            step(0, lfsr[0], lfsr[1] & lfsr[4], lfsr[2], "R9_mixed");
        end
        step(0, 1, 0, 0, "R2_prefill");
        step(0, 1, 0, 1, "R2_prefill_spike");
        step(1, 1, 0, 1, "R1_mid_reset");
        step(0, 0, 0, 1, "R1_after_reset");
        step(0, 0, 0, 0, "R8_tail");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule